// File: doc/BRIEF.md
# Hourly Chime Tone Generator

This block sounds a short run of beeps just before each full hour of a running clock. It watches the binary-coded-decimal minute and second digits of a time-of-day counter. When the minute reads 59, it drives a square wave onto a single buzzer output during a fixed set of odd seconds near the end of that minute. The final beep is at twice the pitch of the earlier ones.

Both tones come from dividing the system clock. Each tone has its own free-running divider, restarted only by reset. A beep therefore begins on whatever phase its divider happens to be in. The digit decoder and the output multiplexer never disturb the dividers. An enable input silences the chime completely.

Top module: `hour_chime_gen`

## Requirements
- R1: While reset is high and on the first cycle after it, the buzzer output is 0. The reset is synchronous and active high.
- R2: When the minute digits are not tens=5, ones=9, the buzzer output is 0.
- R3: In minute 59, when the second digits are tens=5 with ones 3, 5 or 7, the output follows the low-tone square wave. That wave toggles every CLK_HZ/(2*LOW_HZ) clocks, which is 24000 at the defaults (48 MHz, 1 kHz).
- R4: In minute 59, when the second digits are tens=5, ones=9, the output follows the high-tone square wave. That wave toggles every CLK_HZ/(2*HIGH_HZ) clocks, which is 12000 at the defaults (2 kHz).
- R5: In minute 59, every other second value gives an output of 0. This includes the even seconds between the beeps and all seconds outside 53..59.
- R6: While the enable input is 0, the output is 0 whatever the time digits are.
- R7: Both tone waves start low at reset release, with their counters at 0, and they run on every clock. A beep starts on the wave's current phase. When the wave next toggles is set only by the number of clocks since reset.
- R8: The output is registered. It reflects the digit and enable inputs present before the previous rising clock edge, gated by the tone wave value of that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Chime enable; 0 silences the output |
| min_tens | input | 4 | Minute tens digit, BCD |
| min_ones | input | 4 | Minute ones digit, BCD |
| sec_tens | input | 4 | Second tens digit, BCD |
| sec_ones | input | 4 | Second ones digit, BCD |
| buzz | output | 1 | Square-wave buzzer drive |

## Verification
The hardest case to reach is a beep that begins partway through a tone period, on the phase the free-running divider has reached by then. A wrong phase looks like a correct square wave unless the bench counts the clocks since reset itself. The bench runs with small divider settings, so many periods fit in a short run. It keeps its own count of clocks since reset and changes the digits at arbitrary cycle offsets. Directed segments switch from a silent second straight into a beep at an odd offset, and from the last low pip into the high pip.

// File: rtl/hour_chime_pkg.sv
package hour_chime_pkg;
  typedef enum logic [1:0] {
    TONE_OFF  = 2'd0,
    TONE_LOW  = 2'd1,
    TONE_HIGH = 2'd2
  } tone_sel_t;

  localparam int NUM_TONES = 2;
endpackage

// File: rtl/chime_tone_div.sv
module chime_tone_div #(
  parameter int HALF = 24000
) (
  input  logic clk,
  input  logic rst,
  output logic wave
);
  localparam int CW = (HALF < 2) ? 1 : $clog2(HALF);
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      wave <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      wave <= ~wave;
    end else begin
      cnt  <= cnt + 1'b1;
    end
  end

  // R7: counter never leaves its range
  p_cnt_range_r7: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
  // R3/R4: the wave changes only after a full half period
  p_wave_step_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(wave) |-> $past(cnt) == LAST);
endmodule

// File: rtl/chime_window_dec.sv
module chime_window_dec
  import hour_chime_pkg::*;
(
  input  logic [3:0] min_tens,
  input  logic [3:0] min_ones,
  input  logic [3:0] sec_tens,
  input  logic [3:0] sec_ones,
  output tone_sel_t  sel
);
  logic last_minute;
  logic late_second;

  always_comb begin
    last_minute = (min_tens == 4'd5) && (min_ones == 4'd9);
    late_second = (sec_tens == 4'd5);
    sel = TONE_OFF;
    if (last_minute && late_second) begin
      unique case (sec_ones)
        4'd3, 4'd5, 4'd7: sel = TONE_LOW;
        4'd9:             sel = TONE_HIGH;
        default:          sel = TONE_OFF;
      endcase
    end
  end
endmodule

// File: rtl/hour_chime_gen.sv
module hour_chime_gen
  import hour_chime_pkg::*;
#(
  parameter int CLK_HZ  = 48_000_000,
  parameter int LOW_HZ  = 1000,
  parameter int HIGH_HZ = 2000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic [3:0] min_tens,
  input  logic [3:0] min_ones,
  input  logic [3:0] sec_tens,
  input  logic [3:0] sec_ones,
  output logic       buzz
);
  localparam int LOW_HALF  = CLK_HZ / (2 * LOW_HZ);
  localparam int HIGH_HALF = CLK_HZ / (2 * HIGH_HZ);

  logic [NUM_TONES-1:0] waves;
  tone_sel_t            sel;

  for (genvar g = 0; g < NUM_TONES; g++) begin : g_tone
    localparam int H = (g == 0) ? LOW_HALF : HIGH_HALF;
    chime_tone_div #(.HALF(H)) u_div (
      .clk  (clk),
      .rst  (rst),
      .wave (waves[g])
    );
  end

  chime_window_dec u_dec (
    .min_tens (min_tens),
    .min_ones (min_ones),
    .sec_tens (sec_tens),
    .sec_ones (sec_ones),
    .sel      (sel)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      buzz <= 1'b0;
    end else begin
      unique case (sel)
        TONE_LOW:  buzz <= en & waves[0];
        TONE_HIGH: buzz <= en & waves[1];
        default:   buzz <= 1'b0;
      endcase
    end
  end

  // R1: reset forces silence on the next cycle
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> !buzz);
  // R2: silent outside minute 59
  p_minute_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !(min_tens == 4'd5 && min_ones == 4'd9) |=> !buzz);
  // R6: disabled chime stays silent
  p_enable_mask_r6: assert property (@(posedge clk) disable iff (rst)
    !en |=> !buzz);
  // R4: final pip follows the high tone
  p_high_pip_r4: assert property (@(posedge clk) disable iff (rst)
    (en && sel == TONE_HIGH) |=> buzz == $past(waves[1]));
  // R3: earlier pips follow the low tone
  p_low_pip_r3: assert property (@(posedge clk) disable iff (rst)
    (en && sel == TONE_LOW) |=> buzz == $past(waves[0]));
endmodule

// File: tb/tb_hour_chime_gen.sv
module tb_hour_chime_gen;
  localparam int CLK_HZ  = 48000;
  localparam int LOW_HZ  = 1000;
  localparam int HIGH_HZ = 2000;
  localparam int LH = CLK_HZ / (2 * LOW_HZ);
  localparam int HH = CLK_HZ / (2 * HIGH_HZ);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic [3:0] min_tens = 4'd0, min_ones = 4'd0, sec_tens = 4'd0, sec_ones = 4'd0;
  logic buzz;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hour_chime_gen #(.CLK_HZ(CLK_HZ), .LOW_HZ(LOW_HZ), .HIGH_HZ(HIGH_HZ)) dut (
    .clk(clk), .rst(rst), .en(en),
    .min_tens(min_tens), .min_ones(min_ones),
    .sec_tens(sec_tens), .sec_ones(sec_ones),
    .buzz(buzz)
  );

  // tone class from the requirements: 0 silent, 1 low, 2 high
  function automatic int tone_of(logic [3:0] mt, logic [3:0] mo,
                                 logic [3:0] st, logic [3:0] so);
    if (mt != 4'd5 || mo != 4'd9 || st != 4'd5) return 0;
    if (so == 4'd3 || so == 4'd5 || so == 4'd7) return 1;
    if (so == 4'd9) return 2;
    return 0;
  endfunction

  function automatic logic wave_at(int n, int half);
    return logic'((n / half) % 2);
  endfunction

  // expected output from clocks since reset (R7, R8)
  int   n_clk;
  logic exp_buzz;
  always @(posedge clk) begin
    if (rst) begin
      n_clk    <= 0;
      exp_buzz <= 1'b0;
    end else begin
      case (tone_of(min_tens, min_ones, sec_tens, sec_ones))
        1:       exp_buzz <= en & wave_at(n_clk, LH);
        2:       exp_buzz <= en & wave_at(n_clk, HH);
        default: exp_buzz <= 1'b0;
      endcase
      n_clk <= n_clk + 1;
    end
  end

  function automatic string auto_tag();
    int t;
    if (!en) return "R6";
    if (min_tens != 4'd5 || min_ones != 4'd9) return "R2";
    t = tone_of(min_tens, min_ones, sec_tens, sec_ones);
    if (t == 1) return "R3";
    if (t == 2) return "R4";
    return "R5";
  endfunction

  task automatic check(string tag);
    checks++;
    if (buzz !== exp_buzz) begin
      errors++;
      $display("FAIL %s: buzz=%0b expected=%0b at clock %0d", tag, buzz, exp_buzz, n_clk);
    end
  endtask

  // drive digits at a negedge, then check each following negedge
  task automatic run_seg(logic e, int m, int s, int cyc, string tag);
    en = e;
    min_tens = 4'(m / 10); min_ones = 4'(m % 10);
    sec_tens = 4'(s / 10); sec_ones = 4'(s % 10);
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (i == 0 && tag == "") check("R8");
      else check(tag == "" ? auto_tag() : tag);
    end
  endtask

  initial begin
    int secs[8];
    int unused;
    secs = '{53, 55, 57, 59, 54, 58, 52, 0};
    unused = $urandom(32'd1234);
    en = 1'b1;
    min_tens = 4'd5; min_ones = 4'd9; sec_tens = 4'd5; sec_ones = 4'd9;
    repeat (4) begin
      @(negedge clk);
      checks++;
      if (buzz !== 1'b0) begin
        errors++;
        $display("FAIL R1: buzz=%0b expected=0 during reset", buzz);
      end
    end
    rst = 1'b0;
    @(negedge clk); check("R1");
    // directed: first pip mid-phase, then whole pattern
    run_seg(1'b1, 59, 52, 7, "R5");
    run_seg(1'b1, 59, 53, 3 * LH, "R7");
    run_seg(1'b1, 59, 54, 11, "");
    run_seg(1'b1, 59, 55, 2 * LH, "");
    run_seg(1'b1, 59, 56, 5, "");
    run_seg(1'b1, 59, 57, LH + 3, "R3");
    run_seg(1'b1, 59, 59, 4 * HH + 5, "R4");
    run_seg(1'b1, 0, 0, 30, "R2");
    run_seg(1'b1, 58, 59, 30, "R2");
    run_seg(1'b0, 59, 59, 30, "R6");
    run_seg(1'b1, 59, 58, 20, "R5");
    run_seg(1'b1, 59, 3, 20, "R5");
    // random segments
    for (int k = 0; k < 400; k++) begin
      int r, m, s, c;
      logic e;
      r = $urandom_range(0, 9);
      m = (r < 7) ? 59 : $urandom_range(0, 59);
      s = (r < 5) ? secs[$urandom_range(0, 7)] : $urandom_range(0, 59);
      e = ($urandom_range(0, 7) != 0);
      c = $urandom_range(1, 3 * LH);
      run_seg(e, m, s, c, "");
    end
    // reset mid-beep
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk); check("R1");
    rst = 1'b0;
    run_seg(1'b1, 59, 59, 3 * HH, "R7");
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule